// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Controller

This block is the digital sequencer for one phase of a synchronous buck power stage. Analog comparators in front of it classify the PWM pin into three regions: high, low, or a mid-level band that the pin settles into when the controller lets it float. The block reads those classifications, a diode-emulation enable, a zero-crossing flag and a floating flag for that enable. It also reads gate-low sense flags from both switches and an under-voltage flag. From these it drives enables for the high-side gate (GH) and the low-side gate (GL).

Every asynchronous input first passes through a two-stage synchronizer, and all delays are counted in system clock cycles. The sequencer applies a fixed dead time that also waits on adaptive gate sense, so a switch turns on only once the opposite gate is confirmed low. A mid-level PWM that lasts through a hold-off window turns both switches off. If the diode-emulation enable also floats at that point, the block enters a shutdown state. With diode emulation active, the low-side switch opens at the first zero crossing seen after a blanking window. A short PWM-high request is stretched to a minimum on-time.

Top module: `buck_gate_ctrl`

## Requirements
- R1: While `rst_ni` is low, and for as long as the synchronized under-voltage flag is set, both gates are off. Raising `uvlo_i` clears both gate outputs in the same cycle, without waiting for a clock edge.
- R2: PWM high is `pwm_hi_i`=1 with `pwm_lo_i`=0. When it follows PWM low, GL goes off first and GH comes on later. GH rises no earlier than DEAD_CYC+1 cycles after GL fell, and only once the synchronized GL sense flag is set.
- R3: PWM low is `pwm_lo_i`=1 with `pwm_hi_i`=0. When it follows PWM high, GH goes off first and GL comes on later, under the same dead-time and sense rule, using the GH sense flag.
- R4: A switch stays off for as long as the sense flag of the opposite gate reports that gate as not low, however long that lasts.
- R5: GH and GL are never asserted in the same cycle.
- R6: Any other pwm_hi_i/pwm_lo_i combination is mid-level. Mid-level held for HOLD_CYC+1 synchronized cycles turns both gates off. A shorter mid-level excursion leaves both gates as they were.
- R7: With `de_en_ni`=0 and PWM low, GL turns on normally. A zero-crossing flag (`zc_i`=1) is ignored for BLANK_CYC cycles after GL rises. After that window, the flag turns GL off, and GL stays off until PWM goes high.
- R8: With `de_en_ni`=1, GL stays on for as long as PWM is low, whatever the state of `zc_i`.
- R9: A mid-level PWM that outlasts the hold-off turns GL off even in diode-emulation mode with no zero crossing.
- R10: If the hold-off expires while `de_float_i`=1, the block enters shutdown. In shutdown both gates stay off and PWM high is ignored until `de_float_i` returns to 0.
- R11: Once a PWM-high request reaches the sequencer, GH is held on for at least MIN_ON_CYC cycles, even if PWM is high for only one cycle.
- R12: When PWM leaves mid-level or shutdown for high or low, normal sequencing resumes and the gate matching the new level comes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 1 | PWM comparator: above the high threshold |
| pwm_lo_i | input | 1 | PWM comparator: below the low threshold |
| de_en_ni | input | 1 | Diode-emulation enable, active low |
| de_float_i | input | 1 | Diode-emulation enable pin detected floating |
| zc_i | input | 1 | Inductor current zero-crossing flag |
| gh_sns_lo_i | input | 1 | High-side gate sensed below turn-on level |
| gl_sns_lo_i | input | 1 | Low-side gate sensed below turn-on level |
| uvlo_i | input | 1 | Supply under-voltage lockout flag |
| gh_o | output | 1 | High-side gate enable |
| gl_o | output | 1 | Low-side gate enable |

## Verification
The assertions assume that each gate-sense flag follows its own gate output. They also assume that an under-voltage pulse lasts longer than the synchronizer, since the dead-time and minimum on-time properties exclude only the cycles in which the raw or synchronized flag is set. The bench models each sense flag as the inverse of its gate output, with a switch that can hold the low-side sense flag in the not-low state. Every PWM level and enable is held for several cycles, apart from one deliberate single-cycle high pulse. The bench never drives both comparator flags high at once.

// File: rtl/gd_pkg.sv
package gd_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_MID  = 2'd2
  } pwm_lvl_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_DT_H,
    ST_GH,
    ST_DT_L,
    ST_GL,
    ST_DE_IDLE,
    ST_SHDN
  } gd_state_e;
endpackage

// File: rtl/gd_sync.sv
module gd_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gd_level_decode.sv
module gd_level_decode
  import gd_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hi_i,
  input  logic     lo_i,
  output pwm_lvl_e lvl_o,
  output logic     tri_hit_o
);
  localparam int             HW       = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0]  HOLD_MAX = HW'(HOLD_CYC);

  logic [HW-1:0] hold_q;

  always_comb begin
    if (hi_i && !lo_i)      lvl_o = LVL_HIGH;
    else if (lo_i && !hi_i) lvl_o = LVL_LOW;
    else                    lvl_o = LVL_MID;
  end

  // hold-off timer restarts whenever the pin leaves the mid band
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= '0;
    else if (lvl_o != LVL_MID)   hold_q <= '0;
    else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
  end

  assign tri_hit_o = (lvl_o == LVL_MID) && (hold_q == HOLD_MAX);
endmodule

// File: rtl/gd_seq.sv
module gd_seq
  import gd_pkg::*;
#(
  parameter int DEAD_CYC   = 3,
  parameter int BLANK_CYC  = 6,
  parameter int MIN_ON_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pwm_lvl_e lvl_i,
  input  logic     tri_hit_i,
  input  logic     uvlo_i,
  input  logic     de_en_ni,
  input  logic     de_float_i,
  input  logic     zc_i,
  input  logic     gh_sns_lo_i,
  input  logic     gl_sns_lo_i,
  output logic     gh_q_o,
  output logic     gl_q_o
);
  localparam int TMAX0 = (DEAD_CYC > BLANK_CYC) ? DEAD_CYC : BLANK_CYC;
  localparam int TMAX  = (TMAX0 > MIN_ON_CYC) ? TMAX0 : MIN_ON_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_SAT   = TW'(TMAX);
  localparam logic [TW-1:0] T_DEAD  = TW'(DEAD_CYC);
  localparam logic [TW-1:0] T_BLANK = TW'(BLANK_CYC);
  localparam logic [TW-1:0] T_MINON = TW'(MIN_ON_CYC - 1);

  gd_state_e     state_q, state_d;
  logic [TW-1:0] tmr_q;

  always_comb begin
    state_d = state_q;
    if (uvlo_i) begin
      state_d = ST_OFF;
    end else if (tri_hit_i) begin
      state_d = de_float_i ? ST_SHDN : ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (lvl_i == LVL_HIGH)     state_d = ST_DT_H;
          else if (lvl_i == LVL_LOW) state_d = ST_DT_L;
        end
        ST_SHDN: if (!de_float_i) state_d = ST_OFF;
        // high-side request is committed once accepted: stretches short pulses
        ST_DT_H: if (gl_sns_lo_i && tmr_q >= T_DEAD) state_d = ST_GH;
        ST_GH:   if (lvl_i == LVL_LOW && tmr_q >= T_MINON) state_d = ST_DT_L;
        ST_DT_L: begin
          if (lvl_i == LVL_HIGH)                      state_d = ST_DT_H;
          else if (gh_sns_lo_i && tmr_q >= T_DEAD)    state_d = ST_GL;
        end
        ST_GL: begin
          if (lvl_i == LVL_HIGH)                          state_d = ST_DT_H;
          else if (!de_en_ni && zc_i && tmr_q >= T_BLANK) state_d = ST_DE_IDLE;
        end
        ST_DE_IDLE: if (lvl_i == LVL_HIGH) state_d = ST_DT_H;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      tmr_q   <= '0;
      gh_q_o  <= 1'b0;
      gl_q_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) tmr_q <= '0;
      else if (tmr_q != T_SAT) tmr_q <= tmr_q + 1'b1;
      gh_q_o <= (state_d == ST_GH);
      gl_q_o <= (state_d == ST_GL);
    end
  end
endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl
  import gd_pkg::*;
#(
  parameter int DEAD_CYC    = 3,
  parameter int HOLD_CYC    = 8,
  parameter int BLANK_CYC   = 6,
  parameter int MIN_ON_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  input  logic de_en_ni,
  input  logic de_float_i,
  input  logic zc_i,
  input  logic gh_sns_lo_i,
  input  logic gl_sns_lo_i,
  input  logic uvlo_i,
  output logic gh_o,
  output logic gl_o
);
  localparam int NSYNC = 8;
  // reset image: lockout set, emulation disabled, sense flags not low
  localparam logic [NSYNC-1:0] SYNC_RST = 8'b1000_0100;

  logic [NSYNC-1:0] raw_in, syn;
  logic pwm_hi_s, pwm_lo_s, de_en_n_s, de_float_s, zc_s;
  logic gh_sns_s, gl_sns_s, uvlo_s;
  pwm_lvl_e pwm_lvl;
  logic tri_hit, gh_q, gl_q;

  assign raw_in = {uvlo_i, gl_sns_lo_i, gh_sns_lo_i, zc_i,
                   de_float_i, de_en_ni, pwm_lo_i, pwm_hi_i};

  gd_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  assign {uvlo_s, gl_sns_s, gh_sns_s, zc_s,
          de_float_s, de_en_n_s, pwm_lo_s, pwm_hi_s} = syn;

  gd_level_decode #(.HOLD_CYC(HOLD_CYC)) i_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_i     (pwm_hi_s),
    .lo_i     (pwm_lo_s),
    .lvl_o    (pwm_lvl),
    .tri_hit_o(tri_hit)
  );

  gd_seq #(
    .DEAD_CYC  (DEAD_CYC),
    .BLANK_CYC (BLANK_CYC),
    .MIN_ON_CYC(MIN_ON_CYC)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lvl_i      (pwm_lvl),
    .tri_hit_i  (tri_hit),
    .uvlo_i     (uvlo_s),
    .de_en_ni   (de_en_n_s),
    .de_float_i (de_float_s),
    .zc_i       (zc_s),
    .gh_sns_lo_i(gh_sns_s),
    .gl_sns_lo_i(gl_sns_s),
    .gh_q_o     (gh_q),
    .gl_q_o     (gl_q)
  );

  // raw lockout clamps the gates without waiting for the synchronizer
  assign gh_o = gh_q & ~uvlo_i;
  assign gl_o = gl_q & ~uvlo_i;
endmodule

// File: rtl/gd_checker.sv
module gd_checker
  import gd_pkg::*;
#(
  parameter int HOLD_CYC   = 8,
  parameter int BLANK_CYC  = 6,
  parameter int MIN_ON_CYC = 4
) (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     gh_o,
  input logic     gl_o,
  input logic     uvlo_i,
  input logic     uvlo_s,
  input logic     gh_sns_s,
  input logic     gl_sns_s,
  input logic     de_en_n_s,
  input logic     zc_s,
  input pwm_lvl_e pwm_lvl
);
  localparam int RUN_CAP = 1024;

  int mid_run, gh_run, gl_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_run <= 0;
      gh_run  <= 0;
      gl_run  <= 0;
    end else begin
      if (pwm_lvl != LVL_MID)       mid_run <= 0;
      else if (mid_run <= HOLD_CYC) mid_run <= mid_run + 1;
      if (!gh_o)                    gh_run <= 0;
      else if (gh_run < RUN_CAP)    gh_run <= gh_run + 1;
      if (!gl_o)                    gl_run <= 0;
      else if (gl_run < RUN_CAP)    gl_run <= gl_run + 1;
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gh_o && gl_o));

  assert_uvlo_clamp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> (!gh_o && !gl_o));

  assert_gh_after_gl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gh_o) && $past(!uvlo_i)) |-> ($past(!gl_o) && $past(gl_sns_s)));

  assert_gl_after_gh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gl_o) && $past(!uvlo_i)) |-> ($past(!gh_o) && $past(gh_sns_s)));

  assert_holdoff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_run > HOLD_CYC) |-> (!gh_o && !gl_o));

  assert_min_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gh_o) && $past(pwm_lvl == LVL_LOW) && $past(!uvlo_s) && $past(!uvlo_i) && !uvlo_i)
      |-> (gh_run >= MIN_ON_CYC));

  // covers R8 too: with emulation off GL never drops while PWM is low
  assert_de_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gl_o) && $past(pwm_lvl == LVL_LOW) && $past(!uvlo_s) && $past(!uvlo_i) && !uvlo_i)
      |-> ($past(!de_en_n_s) && $past(zc_s) && gl_run > BLANK_CYC));
endmodule

bind buck_gate_ctrl gd_checker #(
  .HOLD_CYC  (HOLD_CYC),
  .BLANK_CYC (BLANK_CYC),
  .MIN_ON_CYC(MIN_ON_CYC)
) i_gd_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gh_o     (gh_o),
  .gl_o     (gl_o),
  .uvlo_i   (uvlo_i),
  .uvlo_s   (uvlo_s),
  .gh_sns_s (gh_sns_s),
  .gl_sns_s (gl_sns_s),
  .de_en_n_s(de_en_n_s),
  .zc_s     (zc_s),
  .pwm_lvl  (pwm_lvl)
);

// File: tb/test_buck_gate_ctrl.sv
module test_buck_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEAD_CYC   = 3;
  localparam int HOLD_CYC   = 8;
  localparam int BLANK_CYC  = 6;
  localparam int MIN_ON_CYC = 4;
  localparam int WDOG_CYC   = 20000;

  logic clk = 1'b0;
  logic rst_ni, pwm_hi, pwm_lo, de_en_n, de_float, zc, uvlo;
  logic gl_stuck;
  logic gh_o, gl_o;
  logic gh_sns, gl_sns;

  always #(CLK_PERIOD/2) clk = ~clk;

  // gate sense model: a gate reads low once its enable is off
  assign gh_sns = ~gh_o;
  assign gl_sns = gl_stuck ? 1'b0 : ~gl_o;

  buck_gate_ctrl #(
    .DEAD_CYC  (DEAD_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .BLANK_CYC (BLANK_CYC),
    .MIN_ON_CYC(MIN_ON_CYC)
  ) i_buck_gate_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pwm_hi_i   (pwm_hi),
    .pwm_lo_i   (pwm_lo),
    .de_en_ni   (de_en_n),
    .de_float_i (de_float),
    .zc_i       (zc),
    .gh_sns_lo_i(gh_sns),
    .gl_sns_lo_i(gl_sns),
    .uvlo_i     (uvlo),
    .gh_o       (gh_o),
    .gl_o       (gl_o)
  );

  typedef struct {
    logic  gh;
    logic  gl;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec  = 0;
  int   n_miss = 0;
  int   overlap_cnt = 0;
  int   gh_hi_cnt = 0;
  bit   done = 1'b0;

  always @(negedge clk) begin
    if (gh_o && gl_o) overlap_cnt++;
    if (gh_o) gh_hi_cnt++;
  end

  // monitor: pops expected gate pairs and compares them with the outputs
  initial begin
    forever begin
      exp_t e;
      wait (sb_q.size() != 0);
      e = sb_q.pop_front();
      n_vec++;
      if (gh_o !== e.gh || gl_o !== e.gl) begin
        n_miss++;
        $display("FAIL %s: gh=%0b gl=%0b expected gh=%0b gl=%0b", e.tag, gh_o, gl_o, e.gh, e.gl);
      end
    end
  end

  task automatic push(input logic gh, input logic gl, input string tag);
    exp_t e;
    #1;
    e.gh = gh; e.gl = gl; e.tag = tag;
    sb_q.push_back(e);
    #1;
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 low, 1 high, 2 mid
  task automatic set_pwm(input int mode);
    pwm_hi = (mode == 1);
    pwm_lo = (mode == 0);
  endtask

  initial begin
    rst_ni = 1'b0; uvlo = 1'b1; de_en_n = 1'b1; de_float = 1'b0;
    zc = 1'b0; gl_stuck = 1'b0;
    set_pwm(2);
    wait_neg(3);
    push(0, 0, "R1 reset state");
    rst_ni = 1'b1;

    set_pwm(1);
    wait_neg(10);
    push(0, 0, "R1 lockout holds gates at start-up");
    uvlo = 1'b0;
    wait_neg(15);
    push(1, 0, "R12 gh on after lockout release");
    uvlo = 1'b1;
    push(0, 0, "R1 immediate clamp");
    wait_neg(5);
    push(0, 0, "R1 clamp held");
    uvlo = 1'b0;
    wait_neg(15);
    push(1, 0, "R1 recovery");

    // high -> low, continuous conduction
    set_pwm(0);
    wait_neg(2);
    push(1, 0, "R3 gh still on before sync");
    wait_neg(1);
    push(0, 0, "R3 gh off first");
    wait_neg(3);
    push(0, 0, "R3 dead time");
    wait_neg(1);
    push(0, 1, "R3 gl on");
    zc = 1'b1;
    wait_neg(30);
    push(0, 1, "R8 forced conduction ignores zero crossing");
    zc = 1'b0;

    // low -> high
    set_pwm(1);
    wait_neg(2);
    push(0, 1, "R2 gl still on before sync");
    wait_neg(1);
    push(0, 0, "R2 gl off first");
    wait_neg(3);
    push(0, 0, "R2 dead time");
    wait_neg(1);
    push(1, 0, "R2 gh on");

    // short mid excursion
    set_pwm(2);
    wait_neg(3);
    push(1, 0, "R6 short mid keeps gh");
    set_pwm(1);
    wait_neg(10);
    push(1, 0, "R6 gh kept after short mid");

    // long mid excursion
    set_pwm(2);
    wait_neg(10);
    push(1, 0, "R6 gh before hold-off expires");
    wait_neg(1);
    push(0, 0, "R6 hold-off expired");
    set_pwm(1);
    wait_neg(15);
    push(1, 0, "R12 resume high after mid");

    // diode emulation with zero crossing present from the start
    de_en_n = 1'b0; zc = 1'b1;
    wait_neg(5);
    set_pwm(0);
    wait_neg(7);
    push(0, 1, "R7 gl on in emulation");
    wait_neg(6);
    push(0, 1, "R7 zero crossing blanked");
    wait_neg(1);
    push(0, 0, "R7 gl off at zero crossing");
    wait_neg(10);
    push(0, 0, "R7 gl stays off while low");

    // mid overrides emulation
    zc = 1'b0;
    set_pwm(1);
    wait_neg(15);
    push(1, 0, "R12 gh from emulation idle");
    set_pwm(0);
    wait_neg(15);
    push(0, 1, "R9 gl on in emulation");
    set_pwm(2);
    wait_neg(20);
    push(0, 0, "R9 mid overrides emulation");
    set_pwm(0);
    wait_neg(15);
    push(0, 1, "R12 resume low after mid");

    // single-cycle high pulse
    de_en_n = 1'b1;
    wait_neg(5);
    @(posedge clk);
    gh_hi_cnt = 0;
    @(negedge clk);
    set_pwm(1);
    @(negedge clk);
    set_pwm(0);
    wait_neg(30);
    chk_int("R11 minimum on-time cycles", gh_hi_cnt, MIN_ON_CYC);
    push(0, 1, "R11 back to gl after stretch");

    // adaptive sense
    gl_stuck = 1'b1;
    set_pwm(1);
    wait_neg(25);
    push(0, 0, "R4 gh waits for gl sense");
    gl_stuck = 1'b0;
    wait_neg(10);
    push(1, 0, "R4 gh on after gl sense");

    // shutdown
    set_pwm(2); de_float = 1'b1;
    wait_neg(20);
    push(0, 0, "R10 shutdown entered");
    set_pwm(1);
    wait_neg(20);
    push(0, 0, "R10 high ignored in shutdown");
    de_float = 1'b0;
    wait_neg(15);
    push(1, 0, "R10 exit shutdown to gh");

    wait_neg(2);
    chk_int("R5 overlap cycles", overlap_cnt, 0);
    wait (sb_q.size() == 0);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end
endmodule